// File: doc/BRIEF.md
# Shadowed Seconds/Milliseconds Timekeeper

This block keeps wall-clock time as a 32-bit seconds count and a 0..999 milliseconds count, advanced by an asynchronous 32.768 kHz slow clock. It presents that time to a faster register bus. The slow clock is brought into the bus clock domain through a synchroniser. Each of its rising edges becomes a one-cycle tick. A phase-accurate accumulator turns those ticks into milliseconds, so that exactly one thousand milliseconds pass for every `SLOW_HZ` ticks.

Software does not see the running counters directly. The block only republishes the running values into bus-visible registers once per `COPY_PERIOD` ticks (eight by default). It raises a busy flag for the slow period that ends with that copy. Software reads the milliseconds register first. That read also freezes the bus-visible seconds into a shadow register, and a later read of the shadow gives the matching seconds. Software sets the time by writing the seconds register outside the busy window. Counting then continues from the written value, and the milliseconds phase is kept.

The register port is word addressed and has a plain read strobe and a plain write strobe. It has no back-pressure: every access completes, and read data appears on the cycle after the strobe.

Top module: `rtc_shadow_core`

## Requirements
- R1: While reset is asserted and right after it, `busy` is 0, `rdata` is 0, and every register reads 0.
- R2: A rising edge of `slow_clk` passes through a two-flop synchroniser plus one edge flop and yields exactly one tick. With a steady slow clock, `busy` therefore repeats every `COPY_PERIOD` slow periods.
- R3: Each tick adds 1000 to an accumulator modulo `SLOW_HZ`, and milliseconds advance by one on each wrap. Milliseconds are read at word 4, zero-extended. Over any `SLOW_HZ` consecutive ticks they advance by exactly 1000.
- R4: Milliseconds roll over from 999 to 0 and carry one into seconds. Seconds wrap modulo 2^32.
- R5: Word 1 bit 0 and the `busy` pin are 1 for exactly one slow period in every `COPY_PERIOD`. At the tick that ends that period, the bus-visible seconds (word 2) and milliseconds (word 4) take the running values that include that tick.
- R6: A read strobe returns data on the next cycle. `rdata` holds between reads. Unmapped words read 0.
- R7: A read of word 4 copies the bus-visible seconds into the shadow register (word 3) on the same edge. A later read of word 3 returns that value.
- R8: A write to word 2 while busy is 0 loads the running and bus-visible seconds at once. Counting continues from the written value, and the write takes priority over a carry on the same edge.
- R9: A write to word 2 while busy is 1 is dropped and sets a sticky error flag in word 1 bit 1. Writing 1 to word 1 bit 1 clears that flag.
- R10: Writes to words 3, 4 and any unmapped word change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Asynchronous slow timebase (32.768 kHz nominal) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Copy window flag, same as word 1 bit 0 |

## Verification
The bench checks the carry from 999 milliseconds into seconds and the wrap of seconds from all ones to zero. A design that dropped either carry would read back a stuck or wrapped-short count. Over one full window of ticks, milliseconds must come back to the same value with seconds advanced by exactly one. This check exposes an accumulator that drifts or adds a millisecond more than once per tick. Seconds writes are placed both inside and outside the busy window. A design that accepted a write during the copy, or failed to set or clear the sticky flag, would show a wrong seconds value or a wrong status bit. The bench also reads the shadow register straight after a milliseconds read. A design that latched seconds late, or from the running counter, would return a pair that does not match.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W       = 32;
  localparam int MSEC_PER_SEC = 1000;
  localparam int MSEC_W       = $clog2(MSEC_PER_SEC);

  // word map; the bench and software decode these
  localparam int REG_STATUS = 1;
  localparam int REG_SEC    = 2;
  localparam int REG_SHADOW = 3;
  localparam int REG_MSEC   = 4;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= async_in;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign tick = sync_q[STAGES-1] & ~last_q;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count
  import rtc_pkg::*;
#(
  parameter int SLOW_HZ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_sec,
  output logic [DATA_W-1:0] sec,
  output logic [MSEC_W-1:0] msec,
  output logic [DATA_W-1:0] sec_nxt,
  output logic [MSEC_W-1:0] msec_nxt
);
  localparam int ACC_W = $clog2(SLOW_HZ);
  localparam logic [ACC_W:0] STEP_V = (ACC_W+1)'(MSEC_PER_SEC);
  localparam logic [ACC_W:0] LIM_V  = (ACC_W+1)'(SLOW_HZ);
  localparam logic [MSEC_W-1:0] MS_LAST = MSEC_W'(MSEC_PER_SEC - 1);

  logic [ACC_W-1:0]  acc_q, acc_nxt;
  logic [ACC_W:0]    acc_sum;
  logic              ms_step, ms_last;
  logic [DATA_W-1:0] sec_q;
  logic [MSEC_W-1:0] msec_q;

  always_comb begin
    acc_sum  = {1'b0, acc_q} + STEP_V;
    ms_step  = tick && (acc_sum >= LIM_V);
    ms_last  = (msec_q == MS_LAST);
    acc_nxt  = acc_q;
    if (tick) acc_nxt = ms_step ? ACC_W'(acc_sum - LIM_V) : ACC_W'(acc_sum);
    msec_nxt = msec_q;
    if (ms_step) msec_nxt = ms_last ? '0 : msec_q + 1'b1;
    sec_nxt  = sec_q;
    if (load)                  sec_nxt = load_sec;
    else if (ms_step && ms_last) sec_nxt = sec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      msec_q <= '0;
      sec_q  <= '0;
    end else begin
      acc_q  <= acc_nxt;
      msec_q <= msec_nxt;
      sec_q  <= sec_nxt;
    end
  end

  assign sec  = sec_q;
  assign msec = msec_q;

  // R3
  msec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(msec));
  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc_q} < LIM_V);
  // R4
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msec == '0 && $past(msec) == MS_LAST && !$past(load)) |-> sec == $past(sec) + 1'b1);
endmodule

// File: rtl/rtc_copy_sched.sv
module rtc_copy_sched #(
  parameter int COPY_PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic busy,
  output logic copy
);
  localparam int PW = $clog2(COPY_PERIOD);
  localparam logic [PW-1:0] LAST = PW'(COPY_PERIOD - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign busy = (phase_q == LAST);
  assign copy = tick & busy;

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));
  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
  import rtc_pkg::*;
#(
  parameter int SLOW_HZ     = 32768,
  parameter int COPY_PERIOD = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_SEC    = ADDR_W'(REG_SEC);
  localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(REG_SHADOW);
  localparam logic [ADDR_W-1:0] A_MSEC   = ADDR_W'(REG_MSEC);

  logic              tick, copy, busy_w, load;
  logic              sec_wr, stat_clr;
  logic [DATA_W-1:0] run_sec, sec_nxt;
  logic [MSEC_W-1:0] run_msec, msec_nxt;
  logic [DATA_W-1:0] vis_sec_q, shadow_q, rdata_q, rd_mux;
  logic [MSEC_W-1:0] vis_msec_q;
  logic              err_q;

  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slow_clk), .tick(tick));

  rtc_copy_sched #(.COPY_PERIOD(COPY_PERIOD)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy_w), .copy(copy));

  rtc_time_count #(.SLOW_HZ(SLOW_HZ)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_sec(wdata),
    .sec(run_sec), .msec(run_msec), .sec_nxt(sec_nxt), .msec_nxt(msec_nxt));

  assign sec_wr   = wr_en && (addr == A_SEC);
  assign stat_clr = wr_en && (addr == A_STATUS) && wdata[STAT_ERR_BIT];
  assign load     = sec_wr && !busy_w;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STATUS: begin
        rd_mux[STAT_BUSY_BIT] = busy_w;
        rd_mux[STAT_ERR_BIT]  = err_q;
      end
      A_SEC:    rd_mux = vis_sec_q;
      A_SHADOW: rd_mux = shadow_q;
      A_MSEC:   rd_mux = {{(DATA_W-MSEC_W){1'b0}}, vis_msec_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_sec_q  <= '0;
      vis_msec_q <= '0;
      shadow_q   <= '0;
      rdata_q    <= '0;
      err_q      <= 1'b0;
    end else begin
      if (load) begin
        vis_sec_q <= wdata;
      end else if (copy) begin
        vis_sec_q  <= sec_nxt;
        vis_msec_q <= msec_nxt;
      end
      if (sec_wr && busy_w) err_q <= 1'b1;
      else if (stat_clr)    err_q <= 1'b0;
      if (rd_en) rdata_q <= rd_mux;
      if (rd_en && addr == A_MSEC) shadow_q <= vis_sec_q;
    end
  end

  assign rdata = rdata_q;
  assign busy  = busy_w;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !stat_clr) |=> err_q);
  // R9
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && busy_w && !copy) |=> $stable(vis_sec_q));
  // R8
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run_sec == $past(wdata));
  // R7
  shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MSEC) |=> shadow_q == $past(vis_sec_q));
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R5
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> (vis_msec_q == run_msec && vis_sec_q == run_sec));
endmodule

// File: tb/test_rtc_shadow_core.sv
module test_rtc_shadow_core;
  localparam int HZ = 2048;
  localparam int CP = 8;
  localparam int AW = 4;

  logic        clk = 0, rst_n = 0, slow_clk = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;

  int checks = 0, fails = 0;
  bit done = 0;
  int last_a = 0;

  rtc_shadow_core #(.SLOW_HZ(HZ), .COPY_PERIOD(CP), .SYNC_STAGES(2), .ADDR_W(AW)) i_rtc_shadow_core (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      slow_clk = ~slow_clk;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_acc, m_ms, m_vmsec, m_phase;
  logic [31:0] m_run, m_vis, m_shadow, m_rdata;
  bit m_err, h1, h2, h3;

  always @(posedge clk) begin
    bit tk, bsy, ld;
    if (!rst_n) begin
      m_acc = 0; m_ms = 0; m_vmsec = 0; m_phase = 0;
      m_run = 0; m_vis = 0; m_shadow = 0; m_rdata = 0; m_err = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      tk = h2 && !h3;
      h3 = h2; h2 = h1; h1 = slow_clk;
      bsy = (m_phase == CP - 1);
      if (rd_en) begin
        case (int'(addr))
          1: m_rdata = {30'd0, m_err, bsy};
          2: m_rdata = m_vis;
          3: m_rdata = m_shadow;
          4: m_rdata = 32'(m_vmsec);
          default: m_rdata = 0;
        endcase
        if (int'(addr) == 4) m_shadow = m_vis;
      end
      ld = 0;
      if (wr_en && int'(addr) == 2) begin
        if (bsy) m_err = 1;
        else begin ld = 1; m_run = wdata; m_vis = wdata; end
      end
      if (wr_en && int'(addr) == 1 && wdata[1]) m_err = 0;
      if (tk) begin
        m_acc += 1000;
        if (m_acc >= HZ) begin
          m_acc -= HZ;
          if (m_ms == 999) begin
            m_ms = 0;
            if (!ld) m_run = m_run + 1;
          end else m_ms++;
        end
        if (bsy) begin m_phase = 0; m_vis = m_run; m_vmsec = m_ms; end
        else m_phase++;
      end
    end
  end

  function automatic string tag_of(input int a);
    case (a)
      1: return "R9";
      2: return "R8";
      3: return "R7";
      4: return "R3";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 busy", {31'd0, busy}, {31'd0, m_phase == CP - 1});
      chk({tag_of(last_a), " rdata"}, rdata, m_rdata);
    end
  end

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a); rd_en = 1; last_a = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_copy();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, s0, m0;
    int per, wid;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 1; a <= 4; a++) begin
      rd(a, d);
      chk("R1 reg after reset", d, 32'd0);
    end
    // R2 / R5: busy period and width
    while (!busy) @(negedge clk);
    wid = 0;
    while (busy) begin wid++; @(negedge clk); end
    per = wid;
    while (!busy) begin per++; @(negedge clk); end
    chk("R5 busy width", 32'(wid), 32'd4);
    chk("R2 busy period", 32'(per), 32'(CP * 4));
    // R8: load seconds outside busy
    wait_copy();
    wr(2, 32'd100);
    rd(2, d);
    chk("R8 seconds load", d, 32'd100);
    // R7: shadow matches seconds
    wait_copy();
    rd(2, s0);
    rd(4, m0);
    rd(3, d);
    chk("R7 shadow pair", d, s0);
    // R3: one full accumulator window advances exactly one second
    repeat (HZ / CP) wait_copy();
    rd(2, d);
    chk("R3 seconds after window", d, s0 + 32'd1);
    rd(4, d);
    chk("R3 msec after window", d, m0);
    // R9: write during busy dropped, sticky flag, clear
    while (!busy) @(negedge clk);
    wr(2, 32'h55);
    rd(1, d);
    chk("R9 error flag set", {31'd0, d[1]}, 32'd1);
    rd(2, d);
    checks++;
    if (d == 32'h55) begin fails++; $display("FAIL R9 seconds actual=%h expected=not 55", d); end
    wait_copy();
    wr(1, 32'h2);
    rd(1, d);
    chk("R9 error flag cleared", {31'd0, d[1]}, 32'd0);
    // R10: writes to other words ignored
    rd(3, s0);
    wr(3, 32'hDEAD);
    wr(4, 32'hBEEF);
    wr(9, 32'h1234);
    rd(3, d);
    chk("R10 shadow unchanged", d, s0);
    // R6: unmapped read and hold
    rd(9, d);
    chk("R6 unmapped reads zero", d, 32'd0);
    repeat (5) @(negedge clk);
    chk("R6 rdata holds", rdata, 32'd0);
    // R4: seconds wrap modulo 2^32
    wait_copy();
    wr(2, 32'hFFFF_FFFF);
    repeat (HZ / CP + 4) wait_copy();
    rd(2, d);
    checks++;
    if (d > 32'd1) begin fails++; $display("FAIL R4 wrap actual=%h expected=0 or 1", d); end
    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule